// File: doc/BRIEF.md
# Simple Dual-Port Block Memory with 9-Bit Lane Enables

This block is a behavioural model of a block memory with two independently clocked ports: one that only writes and one that only reads. Both ports address the same 13-bit address space. The address counts single bits, so each port picks a data width of 1, 2, 4, 9 or 18 bits, and the low address bits that fall inside one word of that width are ignored. Storage is organised as 9-bit lanes. At 1, 2 and 4 bits only the low eight bits of each lane can be reached. At 9 bits one port word is one lane, and at 18 bits it is a pair of lanes.

The write port has a single write enable. At 18 bits it also has two lane enables, so either half of the word can be updated alone. The read port registers its output and has a clock enable. Its reset clears the output to zero and does not depend on that enable. A parameter chooses whether the reset acts at the next read edge or at once. The output register is zero at power-up. A parameter preloads the memory contents, and for each port a parameter selects whether the rising or the falling clock edge is active.

Top module: `sdp_bram`

## Requirements
- R1: At write width 18, a write with w_en high updates lane {w_addr[12:4],0} (data bits 8:0) only when w_be[0] is 1, and lane {w_addr[12:4],1} (data bits 17:9) only when w_be[1] is 1. A lane whose enable is 0 keeps its contents.
- R2: At write widths of 9 bits or less, w_be is ignored and w_en alone decides whether a write happens. With w_en low, nothing is written at any width.
- R3: Address mapping: width 18 uses the lane pair addressed by addr[12:4]. Width 9 uses lane addr[12:3]. Widths 1, 2 and 4 use lane addr[12:3] at bit offset addr[2:0] with its low log2(width) bits cleared.
- R4: r_data takes the addressed word at the first active read edge where r_en is 1. While r_en is 0 and reset is inactive, r_data holds its value.
- R5: At read widths below 18, the upper bits of r_data above the width read as zero.
- R6: A read and a write to the same word at the same edge of a shared clock return the contents from before the write.
- R7: With RST_ASYNC=0, r_rst high at an active read edge clears r_data to zero whatever the value of r_en.
- R8: With RST_ASYNC=1, r_data goes to zero as soon as r_rst rises, without waiting for a clock edge.
- R9: r_data is zero at power-up, before any read edge.
- R10: Lane i powers up holding INIT[9*i+8 : 9*i].
- R11: W_NEG=1 or R_NEG=1 moves that port's active edge to the falling edge of its clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| w_clk | input | 1 | Write port clock |
| w_en | input | 1 | Write enable |
| w_be | input | 2 | Lane enables, used only at write width 18 |
| w_addr | input | 13 | Bit-granular write address |
| w_data | input | 18 | Write data, low bits used at narrow widths |
| r_clk | input | 1 | Read port clock |
| r_en | input | 1 | Read clock enable |
| r_rst | input | 1 | Read output reset to zero |
| r_addr | input | 13 | Bit-granular read address |
| r_data | output | 18 | Registered read data, zero-extended |

## Verification
Every stored bit can only be seen through a later read, so a wrong lane, a wrong bit offset or a wrong lane enable shows up as a wrong r_data word one active read edge after the affected word is read back. The checks therefore always read back a written word, and after partial writes they also read its untouched neighbour lane and bits. A read output register that updates when it should hold, or that misses a reset, shows at the very next read edge. An asynchronous reset that waits for a clock edge shows as nonzero data in the half cycle before that edge.

// File: rtl/sdp_bram.sv
module sdp_bram #(
  parameter int ADDR_W = 13,
  parameter int WR_W = 18,
  parameter int RD_W = 18,
  parameter bit W_NEG = 1'b0,
  parameter bit R_NEG = 1'b0,
  parameter bit RST_ASYNC = 1'b0,
  parameter logic [9*(2**(ADDR_W-3))-1:0] INIT = '0
) (
  input  logic              w_clk,
  input  logic              w_en,
  input  logic [1:0]        w_be,
  input  logic [ADDR_W-1:0] w_addr,
  input  logic [17:0]       w_data,
  input  logic              r_clk,
  input  logic              r_en,
  input  logic              r_rst,
  input  logic [ADDR_W-1:0] r_addr,
  output logic [17:0]       r_data
);
  localparam int LANES = 2**(ADDR_W-3);

  logic wclk, rclk;
  assign wclk = w_clk ^ W_NEG;
  assign rclk = r_clk ^ R_NEG;

  logic [8:0] mem [LANES];
  initial for (int i = 0; i < LANES; i++) mem[i] = INIT[9*i +: 9];

  logic [ADDR_W-4:0] wl, rl;
  logic [ADDR_W-5:0] wp, rp;
  assign wl = w_addr[ADDR_W-1:3];
  assign wp = w_addr[ADDR_W-1:4];
  assign rl = r_addr[ADDR_W-1:3];
  assign rp = r_addr[ADDR_W-1:4];

  wire unused_bits = &{1'b0, w_be, w_addr[3:0], r_addr[3:0], w_data};

  generate
    if (WR_W == 18) begin : g_w18
      always_ff @(posedge wclk)
        if (w_en) begin
          if (w_be[0]) mem[{wp, 1'b0}] <= w_data[8:0];
          if (w_be[1]) mem[{wp, 1'b1}] <= w_data[17:9];
        end
    end else if (WR_W == 9) begin : g_w9
      always_ff @(posedge wclk)
        if (w_en) mem[wl] <= w_data[8:0];
    end else begin : g_wn
      logic [2:0] woff;
      assign woff = w_addr[2:0] & 3'(~(WR_W - 1));
      always_ff @(posedge wclk)
        if (w_en) mem[wl][woff +: WR_W] <= w_data[WR_W-1:0];
    end
  endgenerate

  logic [17:0] rword;
  generate
    if (RD_W == 18) begin : g_r18
      assign rword = {mem[{rp, 1'b1}], mem[{rp, 1'b0}]};
    end else if (RD_W == 9) begin : g_r9
      assign rword = {9'b0, mem[rl]};
    end else begin : g_rn
      logic [2:0] roff;
      assign roff = r_addr[2:0] & 3'(~(RD_W - 1));
      assign rword = 18'(mem[rl][roff +: RD_W]);
    end
  endgenerate

  logic [17:0] rq = '0;
  assign r_data = rq;

  generate
    if (RST_ASYNC) begin : g_arst
      always_ff @(posedge rclk or posedge r_rst)
        if (r_rst) rq <= '0;
        else if (r_en) rq <= rword;
    end else begin : g_srst
      always_ff @(posedge rclk)
        if (r_rst) rq <= '0;
        else if (r_en) rq <= rword;
    end
  endgenerate
endmodule

module sdp_bram_chk #(
  parameter int RD_W = 18,
  parameter bit RST_ASYNC = 1'b0
) (
  input logic        rclk,
  input logic        r_rst,
  input logic        r_en,
  input logic [17:0] r_data
);
  generate
    if (RST_ASYNC) begin : g_a
      // R8
      arst_zero_chk: assert property (@(posedge rclk) r_rst |-> r_data == '0);
    end else begin : g_s
      // R7
      srst_zero_chk: assert property (@(posedge rclk) r_rst |=> r_data == '0);
      // R4
      hold_chk: assert property (@(posedge rclk) disable iff (r_rst)
        !r_en |=> $stable(r_data));
    end
    if (RD_W < 18) begin : g_z
      // R5
      upper_zero_chk: assert property (@(posedge rclk) r_data[17:RD_W] == '0);
    end
  endgenerate
endmodule

bind sdp_bram sdp_bram_chk #(.RD_W(RD_W), .RST_ASYNC(RST_ASYNC)) u_chk (
  .rclk(rclk), .r_rst(r_rst), .r_en(r_en), .r_data(r_data)
);

// File: tb/sim_sdp_bram.sv
`timescale 1ns/100ps
module sim_sdp_bram;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic w_en0 = 0, r_en0 = 0, r_rst0 = 0;
  logic [1:0] w_be0 = 0;
  logic [12:0] w_addr0 = 0, r_addr0 = 0;
  logic [17:0] w_data0 = 0, r_data0;

  logic w_en1 = 0, r_en1 = 0, r_rst1 = 0;
  logic [1:0] w_be1 = 0;
  logic [12:0] w_addr1 = 0, r_addr1 = 0;
  logic [17:0] w_data1 = 0, r_data1;

  sdp_bram u0 (
    .w_clk(clk), .w_en(w_en0), .w_be(w_be0), .w_addr(w_addr0), .w_data(w_data0),
    .r_clk(clk), .r_en(r_en0), .r_rst(r_rst0), .r_addr(r_addr0), .r_data(r_data0));

  sdp_bram #(.WR_W(4), .RD_W(9), .R_NEG(1'b1), .RST_ASYNC(1'b1),
             .INIT(9216'({9'h1A5, 45'b0}))) u1 (
    .w_clk(clk), .w_en(w_en1), .w_be(w_be1), .w_addr(w_addr1), .w_data(w_data1),
    .r_clk(clk), .r_en(r_en1), .r_rst(r_rst1), .r_addr(r_addr1), .r_data(r_data1));

  typedef struct { logic [17:0] exp; string tag; } item_t;
  item_t q0[$], q1[$];
  int total = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, logic [17:0] act, logic [17:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  initial forever begin
    int n;
    @(posedge clk); n = q0.size(); #2;
    repeat (n) begin item_t it; it = q0.pop_front(); chk(it.tag, r_data0, it.exp); end
  end

  initial forever begin
    int n;
    @(negedge clk); n = q1.size(); #1;
    repeat (n) begin item_t it; it = q1.pop_front(); chk(it.tag, r_data1, it.exp); end
  end

  task automatic wr0(logic [12:0] a, logic [17:0] d, logic [1:0] be, logic en);
    @(posedge clk); #1; w_addr0 = a; w_data0 = d; w_be0 = be; w_en0 = en;
    @(posedge clk); #1; w_en0 = 0;
  endtask

  task automatic rd0(logic [12:0] a, logic [17:0] e, string tag);
    @(posedge clk); #1; r_addr0 = a; r_en0 = 1; q0.push_back('{e, tag});
    @(posedge clk); #1; r_en0 = 0;
  endtask

  task automatic wr1(logic [12:0] a, logic [3:0] d, logic [1:0] be);
    @(posedge clk); #1; w_addr1 = a; w_data1 = {14'b0, d}; w_be1 = be; w_en1 = 1;
    @(posedge clk); #1; w_en1 = 0;
  endtask

  task automatic rd1(logic [12:0] a, logic [17:0] e, string tag);
    @(posedge clk); #1; r_addr1 = a; r_en1 = 1; q1.push_back('{e, tag});
    @(posedge clk); #1; r_en1 = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    #1;
    chk("R9 power-up u0", r_data0, 18'h0);
    chk("R9 power-up u1", r_data1, 18'h0);

    // u0: 18-bit write and read, sync reset
    wr0(13'd48, {9'h0AD, 9'h05A}, 2'b11, 1'b1);
    rd0(13'd63, {9'h0AD, 9'h05A}, "R3 R4 full word, low addr bits ignored");
    wr0(13'd48, {9'h1FF, 9'h000}, 2'b01, 1'b1);
    rd0(13'd48, {9'h0AD, 9'h000}, "R1 low lane only");
    wr0(13'd48, {9'h123, 9'h1FF}, 2'b10, 1'b1);
    rd0(13'd48, {9'h123, 9'h000}, "R1 high lane only");
    wr0(13'd48, 18'h3FFFF, 2'b00, 1'b1);
    rd0(13'd48, {9'h123, 9'h000}, "R1 no lane enabled");
    wr0(13'd48, 18'h3FFFF, 2'b11, 1'b0);
    rd0(13'd48, {9'h123, 9'h000}, "R2 w_en low");
    rd0(13'd32, 18'h0, "R10 default zero contents");

    @(posedge clk); #1;
    w_addr0 = 13'd48; w_data0 = {9'h011, 9'h022}; w_be0 = 2'b11; w_en0 = 1;
    r_addr0 = 13'd48; r_en0 = 1; q0.push_back('{{9'h123, 9'h000}, "R6 old data on collision"});
    @(posedge clk); #1; w_en0 = 0; r_en0 = 0;
    rd0(13'd48, {9'h011, 9'h022}, "R6 new data after collision");

    @(posedge clk); #1; r_addr0 = 13'd0; r_en0 = 0;
    q0.push_back('{{9'h011, 9'h022}, "R4 hold with r_en low"});
    @(posedge clk); #1; r_rst0 = 1; r_en0 = 0;
    q0.push_back('{18'h0, "R7 sync reset ignores r_en"});
    @(posedge clk); #1; r_rst0 = 0;

    // u1: 4-bit write, 9-bit read on falling edge, async reset, preload
    rd1(13'd40, 18'h1A5, "R10 R11 R5 preload read");
    wr1(13'd44, 4'hC, 2'b00);
    rd1(13'd47, 18'h1C5, "R2 R3 upper nibble, be ignored");
    wr1(13'd41, 4'h3, 2'b00);
    rd1(13'd40, 18'h1C3, "R3 lower nibble");
    @(posedge clk); #1; r_rst1 = 1;
    #0.5; chk("R8 async reset immediate", r_data1, 18'h0);
    #0.5; r_rst1 = 0;
    @(negedge clk); #1; chk("R8 stays zero after release", r_data1, 18'h0);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule